// File: doc/BRIEF.md
# HDLC Receive Byte Packer and Buffer Writer

This block sits behind the flag detector and bit destuffer of a multi-channel HDLC receiver. Each cycle it may accept one destuffed bit, or one end-of-frame marker, tagged with a channel number. Every channel has its own programmable inversion bit. When that bit is set, each received bit of the channel is complemented before use, and this covers flag, abort and FCS bits the same way as payload. The block gathers the bits of each channel into octets, least significant bit first. Each finished octet becomes a byte write to external memory.

Every channel owns a ring of buffer descriptors, each giving a start address and a length in bytes. Bytes of a channel go to consecutive addresses in its current buffer. The channel moves to the next descriptor of its ring at the end of a frame, or when the buffer is full, whichever happens first. A completion pulse reports the channel, the number of bytes stored, whether the frame ended, and how many bits a trailing partial octet holds. Descriptors are loaded through a simple write port. Fetching descriptors from memory is left to the surrounding logic.

Top module: `hdlc_rx_packer`

## Requirements
- R1: After reset there is no memory write and no completion pulse until an input is accepted. Inversion is enabled on every channel, and each channel starts at byte offset 0 of ring slot 0.
- R2: Within an octet, the first accepted bit of a channel is stored at bit 0 of the written byte and the eighth at bit 7.
- R3: A channel whose inversion bit is 1 has every data bit complemented before packing, whatever the bit's role in the frame. A channel whose inversion bit is 0 stores bits unchanged. A change to the bit applies to the bits accepted after the write.
- R4: The n-th byte (n counted from 0) stored in a buffer is written at the descriptor start address plus n, modulo 2^ADDR_W.
- R5: When a byte fills a buffer (n+1 equals the descriptor length), a completion pulse reports count = length, end-of-frame = 0 and residue = 0. The next byte of that channel goes to the start of the next ring slot.
- R6: At an end-of-frame marker with k (1..7) bits pending, those bits are written as one byte at the next address, right-aligned with the upper 8-k bits zero. The completion reports count = bytes stored including this one, end-of-frame = 1 and residue = k. The channel then moves to the next slot.
- R7: At an end-of-frame marker with no bits pending and at least one byte stored in the buffer, nothing is written. The completion reports that byte count, end-of-frame = 1 and residue 0, and the channel moves to the next slot.
- R8: An end-of-frame marker with no bits pending and no bytes stored in the current buffer produces no write and no completion, and the channel stays on its slot.
- R9: The ring index of a channel advances by one on every completion and wraps from NBUF-1 to 0.
- R10: Channels keep separate bit counts, partial bytes, offsets and ring positions, so interleaving bits of different channels does not change what any one channel writes.
- R11: A write and a completion caused by an accepted input appear on the outputs exactly one clock cycle after that input is sampled.
- R12: On an end-of-frame cycle the data-bit input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input is offered this cycle |
| in_ch | input | CH_W | Channel of the input |
| in_bit | input | 1 | Destuffed data bit (ignored when in_eof is 1) |
| in_eof | input | 1 | The input is an end-of-frame marker instead of a bit |
| inv_wr | input | 1 | Write the inversion bit of inv_ch |
| inv_ch | input | CH_W | Channel whose inversion bit is written |
| inv_val | input | 1 | New inversion bit (1 = complement) |
| desc_wr | input | 1 | Write one buffer descriptor |
| desc_ch | input | CH_W | Channel of the descriptor |
| desc_idx | input | IDX_W | Ring slot of the descriptor |
| desc_addr | input | ADDR_W | Buffer start byte address |
| desc_len | input | LEN_W | Buffer length in bytes (1 or more) |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte write address |
| mem_data | output | 8 | Byte write data |
| done_valid | output | 1 | Buffer completion pulse |
| done_ch | output | CH_W | Channel of the completed buffer |
| done_count | output | LEN_W | Bytes stored in the completed buffer |
| done_eof | output | 1 | The buffer was closed by end of frame |
| done_resid | output | 3 | Valid bits in the last byte when it is partial, else 0 |

## Verification
On every cycle the assertions check the output-side invariants. Nothing is written or reported unless an input was accepted the cycle before. A completion caused by a full buffer always comes together with the write that filled it. A partial last byte has zero bits above its residue, a residue only appears when a frame ends, and a completion never reports zero bytes. The exact bit order, the effect of inversion, the address sequence, the ring wrap and the separation between interleaved channels only show up in the bench's scenarios. There, a per-channel model computes each expected write and completion.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int unsigned OCTET_W = 8;
    localparam int unsigned BCNT_W  = 3;

    typedef logic [OCTET_W-1:0] octet_t;
    typedef logic [BCNT_W-1:0]  bcnt_t;

    // kind of work a cycle carries into the packer
    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_BIT  = 2'd1,
        STEP_EOF  = 2'd2
    } step_e;

endpackage

// File: rtl/hdlc_rx_inv_bank.sv
module hdlc_rx_inv_bank #(
    parameter int unsigned NCH  = 32,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [CH_W-1:0] wr_ch,
    input  logic            wr_val,
    input  logic [CH_W-1:0] rd_ch,
    output logic            rd_inv
);

    logic [NCH-1:0] inv_d, inv_q;

    always_comb begin
        inv_d = inv_q;
        if (wr) begin
            inv_d[wr_ch] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= '1;   // every channel starts complemented
        end else begin
            inv_q <= inv_d;
        end
    end

    assign rd_inv = inv_q[rd_ch];

endmodule

// File: rtl/hdlc_rx_desc_ring.sv
module hdlc_rx_desc_ring #(
    parameter int unsigned NCH    = 32,
    parameter int unsigned NBUF   = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 12,
    localparam int unsigned CH_W  = $clog2(NCH),
    localparam int unsigned IDX_W = $clog2(NBUF),
    localparam int unsigned NENT  = NCH * NBUF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len
);

    logic [ADDR_W-1:0] base_d [NENT];
    logic [ADDR_W-1:0] base_q [NENT];
    logic [LEN_W-1:0]  size_d [NENT];
    logic [LEN_W-1:0]  size_q [NENT];

    function automatic int unsigned slot(input logic [CH_W-1:0] c,
                                         input logic [IDX_W-1:0] i);
        return int'(c) * NBUF + int'(i);
    endfunction

    always_comb begin
        base_d = base_q;
        size_d = size_q;
        if (wr) begin
            base_d[slot(wr_ch, wr_idx)] = wr_addr;
            size_d[slot(wr_ch, wr_idx)] = wr_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NENT; k++) begin
                base_q[k] <= '0;
                size_q[k] <= '0;
            end
        end else begin
            base_q <= base_d;
            size_q <= size_d;
        end
    end

    assign rd_addr = base_q[slot(rd_ch, rd_idx)];
    assign rd_len  = size_q[slot(rd_ch, rd_idx)];

endmodule

// File: rtl/hdlc_rx_pack_step.sv
module hdlc_rx_pack_step
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  step_e            kind,
    input  logic             bit_in,
    input  bcnt_t            bcnt,
    input  octet_t           part,
    input  logic [LEN_W-1:0] off,
    input  logic [LEN_W-1:0] len,
    output bcnt_t            nxt_bcnt,
    output octet_t           nxt_part,
    output logic [LEN_W-1:0] nxt_off,
    output logic             adv,
    output logic             wr_en,
    output octet_t           wr_data,
    output logic             done,
    output logic [LEN_W-1:0] done_cnt,
    output logic             done_eof,
    output bcnt_t            done_resid
);

    octet_t           merged;
    logic [LEN_W-1:0] off_inc;

    assign merged  = part | (octet_t'(bit_in) << bcnt);
    assign off_inc = off + LEN_W'(1);

    always_comb begin
        nxt_bcnt   = bcnt;
        nxt_part   = part;
        nxt_off    = off;
        adv        = 1'b0;
        wr_en      = 1'b0;
        wr_data    = '0;
        done       = 1'b0;
        done_cnt   = '0;
        done_eof   = 1'b0;
        done_resid = '0;
        unique case (kind)
            STEP_BIT: begin
                if (bcnt == bcnt_t'(OCTET_W - 1)) begin
                    wr_en    = 1'b1;
                    wr_data  = merged;
                    nxt_part = '0;
                    nxt_bcnt = '0;
                    if (off_inc == len) begin
                        done     = 1'b1;
                        done_cnt = len;
                        adv      = 1'b1;
                        nxt_off  = '0;
                    end else begin
                        nxt_off = off_inc;
                    end
                end else begin
                    nxt_part = merged;
                    nxt_bcnt = bcnt + bcnt_t'(1);
                end
            end
            STEP_EOF: begin
                if (bcnt != '0) begin
                    wr_en      = 1'b1;
                    wr_data    = part;
                    done       = 1'b1;
                    done_cnt   = off_inc;
                    done_eof   = 1'b1;
                    done_resid = bcnt;
                    adv        = 1'b1;
                end else if (off != '0) begin
                    done     = 1'b1;
                    done_cnt = off;
                    done_eof = 1'b1;
                    adv      = 1'b1;
                end
                if (adv) begin
                    nxt_part = '0;
                    nxt_bcnt = '0;
                    nxt_off  = '0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hdlc_rx_packer.sv
module hdlc_rx_packer
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned NCH    = 32,
    parameter int unsigned NBUF   = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 12,
    localparam int unsigned CH_W  = $clog2(NCH),
    localparam int unsigned IDX_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic              in_bit,
    input  logic              in_eof,
    input  logic              inv_wr,
    input  logic [CH_W-1:0]   inv_ch,
    input  logic              inv_val,
    input  logic              desc_wr,
    input  logic [CH_W-1:0]   desc_ch,
    input  logic [IDX_W-1:0]  desc_idx,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              done_valid,
    output logic [CH_W-1:0]   done_ch,
    output logic [LEN_W-1:0]  done_count,
    output logic              done_eof,
    output logic [2:0]        done_resid
);

    typedef struct packed {
        bcnt_t            bcnt;
        octet_t           part;
        logic [LEN_W-1:0] off;
        logic [IDX_W-1:0] idx;
    } chst_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        octet_t            data;
        logic              dv;
        logic [CH_W-1:0]   dch;
        logic [LEN_W-1:0]  dcnt;
        logic              deof;
        bcnt_t             dres;
    } outs_t;

    chst_t st_d [NCH];
    chst_t st_q [NCH];
    outs_t out_d, out_q;

    logic              inv_cur;
    logic [ADDR_W-1:0] base_cur;
    logic [LEN_W-1:0]  size_cur;
    chst_t             cur;
    step_e             kind;
    logic              bit_eff;

    bcnt_t            s_bcnt;
    octet_t           s_part;
    logic [LEN_W-1:0] s_off;
    logic             s_adv;
    logic             s_wr;
    octet_t           s_data;
    logic             s_done;
    logic [LEN_W-1:0] s_cnt;
    logic             s_eof;
    bcnt_t            s_res;

    assign cur     = st_q[in_ch];
    assign bit_eff = in_bit ^ inv_cur;
    assign kind    = !in_valid ? STEP_IDLE : (in_eof ? STEP_EOF : STEP_BIT);

    hdlc_rx_inv_bank #(.NCH(NCH)) u_inv (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (inv_wr),
        .wr_ch  (inv_ch),
        .wr_val (inv_val),
        .rd_ch  (in_ch),
        .rd_inv (inv_cur)
    );

    hdlc_rx_desc_ring #(
        .NCH(NCH), .NBUF(NBUF), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (desc_wr),
        .wr_ch   (desc_ch),
        .wr_idx  (desc_idx),
        .wr_addr (desc_addr),
        .wr_len  (desc_len),
        .rd_ch   (in_ch),
        .rd_idx  (cur.idx),
        .rd_addr (base_cur),
        .rd_len  (size_cur)
    );

    hdlc_rx_pack_step #(.LEN_W(LEN_W)) u_step (
        .kind       (kind),
        .bit_in     (bit_eff),
        .bcnt       (cur.bcnt),
        .part       (cur.part),
        .off        (cur.off),
        .len        (size_cur),
        .nxt_bcnt   (s_bcnt),
        .nxt_part   (s_part),
        .nxt_off    (s_off),
        .adv        (s_adv),
        .wr_en      (s_wr),
        .wr_data    (s_data),
        .done       (s_done),
        .done_cnt   (s_cnt),
        .done_eof   (s_eof),
        .done_resid (s_res)
    );

    always_comb begin
        st_d  = st_q;
        out_d = '0;
        if (kind != STEP_IDLE) begin
            st_d[in_ch].bcnt = s_bcnt;
            st_d[in_ch].part = s_part;
            st_d[in_ch].off  = s_off;
            if (s_adv) begin
                if (cur.idx == IDX_W'(NBUF - 1)) begin
                    st_d[in_ch].idx = '0;
                end else begin
                    st_d[in_ch].idx = cur.idx + IDX_W'(1);
                end
            end
            out_d.we   = s_wr;
            out_d.addr = base_cur + ADDR_W'(cur.off);
            out_d.data = s_data;
            out_d.dv   = s_done;
            out_d.dch  = in_ch;
            out_d.dcnt = s_cnt;
            out_d.deof = s_eof;
            out_d.dres = s_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                st_q[c] <= '0;
            end
            out_q <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
        end
    end

    assign mem_we     = out_q.we;
    assign mem_addr   = out_q.addr;
    assign mem_data   = out_q.data;
    assign done_valid = out_q.dv;
    assign done_ch    = out_q.dch;
    assign done_count = out_q.dcnt;
    assign done_eof   = out_q.deof;
    assign done_resid = out_q.dres;

endmodule

// File: rtl/hdlc_rx_packer_chk.sv
module hdlc_rx_packer_chk #(
    parameter int unsigned LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eof,
    input logic             mem_we,
    input logic [7:0]       mem_data,
    input logic             done_valid,
    input logic [LEN_W-1:0] done_count,
    input logic             done_eof,
    input logic [2:0]       done_resid
);

    // R1 and R11: outputs only move one cycle after an accepted input
    a_r11_quiet_without_input: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!mem_we && !done_valid));

    // R5: a full-buffer completion carries the write that filled it
    a_r5_full_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_eof) |-> mem_we);

    // R6: bits above the residue of a partial byte are zero
    a_r6_partial_right_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && done_valid && done_resid != 3'd0) |-> ((mem_data >> done_resid) == 8'd0));

    // R6: a residue is only reported when a frame ends
    a_r6_resid_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_resid != 3'd0) |-> done_eof);

    // R8: a completion never reports an empty buffer
    a_r8_no_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_count != '0));

    // R12: an end-of-frame marker never produces a write without a completion
    a_r12_eof_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_eof) |-> !(mem_we && !done_valid));

endmodule

bind hdlc_rx_packer hdlc_rx_packer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_eof     (in_eof),
    .mem_we     (mem_we),
    .mem_data   (mem_data),
    .done_valid (done_valid),
    .done_count (done_count),
    .done_eof   (done_eof),
    .done_resid (done_resid)
);

// File: tb/hdlc_rx_packer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_packer_tb;

    localparam int NCH = 32, NBUF = 4, ADDR_W = 16, LEN_W = 12;
    localparam int CH_W = $clog2(NCH), IDX_W = $clog2(NBUF);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, in_eof = 1'b0;
    logic [CH_W-1:0] in_ch = '0;
    logic inv_wr = 1'b0, inv_val = 1'b0;
    logic [CH_W-1:0] inv_ch = '0;
    logic desc_wr = 1'b0;
    logic [CH_W-1:0] desc_ch = '0;
    logic [IDX_W-1:0] desc_idx = '0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0] desc_len = '0;
    logic mem_we, done_valid, done_eof;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_data;
    logic [CH_W-1:0] done_ch;
    logic [LEN_W-1:0] done_count;
    logic [2:0] done_resid;

    always #2 clk = ~clk;   // 250 MHz

    hdlc_rx_packer #(.NCH(NCH), .NBUF(NBUF), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_bit(in_bit),
        .in_eof(in_eof), .inv_wr(inv_wr), .inv_ch(inv_ch), .inv_val(inv_val),
        .desc_wr(desc_wr), .desc_ch(desc_ch), .desc_idx(desc_idx), .desc_addr(desc_addr),
        .desc_len(desc_len), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .done_valid(done_valid), .done_ch(done_ch), .done_count(done_count),
        .done_eof(done_eof), .done_resid(done_resid)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // model state, computed from the requirements
    bit       m_inv [NCH];
    int       m_bc  [NCH];
    int       m_off [NCH];
    int       m_idx [NCH];
    logic [7:0] m_sh [NCH];
    int       d_addr [NCH][NBUF];
    int       d_len  [NCH][NBUF];

    task automatic check(input string tag, input bit ok, input string what,
                         input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic set_inv(input int ch, input bit v);
        inv_wr = 1'b1; inv_ch = CH_W'(ch); inv_val = v;
        @(negedge clk);
        inv_wr = 1'b0;
        m_inv[ch] = v;
    endtask

    task automatic set_desc(input int ch, input int i, input int a, input int l);
        desc_wr = 1'b1; desc_ch = CH_W'(ch); desc_idx = IDX_W'(i);
        desc_addr = ADDR_W'(a); desc_len = LEN_W'(l);
        @(negedge clk);
        desc_wr = 1'b0;
        d_addr[ch][i] = a; d_len[ch][i] = l;
    endtask

    task automatic advance(input int ch);
        m_off[ch] = 0; m_bc[ch] = 0; m_sh[ch] = 8'h00;
        m_idx[ch] = (m_idx[ch] + 1) % NBUF;
    endtask

    // offer one bit or marker and compare outputs one cycle later (R11)
    task automatic step(input int ch, input bit b, input bit eof, input string tag);
        bit e_we = 0, e_dv = 0, e_eof = 0;
        int e_addr = 0, e_cnt = 0, e_res = 0;
        logic [7:0] e_data = 8'h00;
        int len = d_len[ch][m_idx[ch]];
        e_addr = (d_addr[ch][m_idx[ch]] + m_off[ch]) & 16'hFFFF;
        if (!eof) begin
            m_sh[ch][m_bc[ch]] = b ^ m_inv[ch];
            if (m_bc[ch] == 7) begin
                e_we = 1; e_data = m_sh[ch];
                m_sh[ch] = 8'h00; m_bc[ch] = 0;
                if (m_off[ch] + 1 == len) begin
                    e_dv = 1; e_cnt = len;
                    advance(ch);
                end else m_off[ch]++;
            end else m_bc[ch]++;
        end else if (m_bc[ch] != 0) begin
            e_we = 1; e_data = m_sh[ch];
            e_dv = 1; e_eof = 1; e_cnt = m_off[ch] + 1; e_res = m_bc[ch];
            advance(ch);
        end else if (m_off[ch] != 0) begin
            e_dv = 1; e_eof = 1; e_cnt = m_off[ch];
            advance(ch);
        end
        in_valid = 1'b1; in_ch = CH_W'(ch); in_bit = b; in_eof = eof;
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0; in_bit = 1'b0;
        check(tag, mem_we == e_we, "mem_we", mem_we, e_we);
        if (e_we) begin
            check(tag, mem_addr == ADDR_W'(e_addr), "mem_addr", mem_addr, e_addr);
            check(tag, mem_data == e_data, "mem_data", mem_data, e_data);
        end
        check(tag, done_valid == e_dv, "done_valid", done_valid, e_dv);
        if (e_dv) begin
            check(tag, {done_ch, done_count, done_eof, done_resid} ==
                       {CH_W'(ch), LEN_W'(e_cnt), e_eof, 3'(e_res)},
                  "done ch/count/eof/resid",
                  {done_ch, done_count, done_eof, done_resid},
                  {CH_W'(ch), LEN_W'(e_cnt), e_eof, 3'(e_res)});
        end
    endtask

    task automatic send_byte(input int ch, input logic [7:0] v, input string tag);
        for (int k = 0; k < 8; k++) step(ch, v[k], 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_inv[c] = 1; m_bc[c] = 0; m_off[c] = 0; m_idx[c] = 0; m_sh[c] = 8'h00;
            for (int i = 0; i < NBUF; i++) begin
                d_addr[c][i] = 0; d_len[c][i] = 0;
            end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", mem_we == 1'b0, "mem_we after reset", mem_we, 0);
        check("R1", done_valid == 1'b0, "done_valid after reset", done_valid, 0);

        for (int c = 0; c < 4; c++)
            for (int i = 0; i < NBUF; i++)
                set_desc(c, i, (c << 10) + (i << 8) + 3, 2 + i + (c % 3));
        for (int i = 0; i < NBUF; i++) set_desc(31, i, 16'hFFFE - i, 3);

        // inversion on by default after reset
        send_byte(0, 8'hA5, "R1 R3");
        send_byte(0, 8'h0F, "R1 R3");

        // full sweep of byte values, uninverted, across buffer fills and ring wraps
        set_inv(1, 1'b0);
        for (int v = 0; v < 256; v++) send_byte(1, 8'(v), "R2 R4 R5 R9 R11");

        // partial residues at frame end, each 1..7 bits
        for (int r = 1; r < 8; r++) begin
            for (int k = 0; k < r; k++) step(2, (r >> k) & 1, 1'b0, "R6");
            step(2, 1'b0, 1'b1, "R6");
        end
        // aligned frame end, then empty markers with either bit value
        send_byte(2, 8'h3C, "R7");
        step(2, 1'b0, 1'b1, "R7");
        step(2, 1'b1, 1'b1, "R8 R12");
        step(2, 1'b0, 1'b1, "R8");
        send_byte(2, 8'hC3, "R7");
        send_byte(2, 8'h81, "R7");
        step(2, 1'b1, 1'b1, "R7 R12");

        // inversion changed mid-octet
        for (int k = 0; k < 4; k++) step(3, k[0], 1'b0, "R3");
        set_inv(3, 1'b0);
        for (int k = 0; k < 12; k++) step(3, k[1], 1'b0, "R3");
        set_inv(3, 1'b1);
        for (int k = 0; k < 8; k++) step(3, k[2], 1'b0, "R3");
        step(3, 1'b0, 1'b1, "R3 R6");

        // interleaved channels, with address wrap on channel 31
        for (int k = 0; k < 96; k++) begin
            step(0, (k * 5 >> 2) & 1, 1'b0, "R10");
            step(31, (k * 3 >> 1) & 1, 1'b0, "R4 R10");
            if (k % 29 == 28) step(0, 1'b0, 1'b1, "R10 R6");
        end
        step(31, 1'b0, 1'b1, "R10");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule